// File: doc/BRIEF.md
# Unlock-Sequence Protected Register Guard

This block shields two critical control registers, a clock multiplier select and a flash programming mode byte, from stray stores by software that has run away. It sits on a simple byte-lane register bus. The bus carries a byte address, 32-bit write data, four byte enables, a write strobe, a read strobe and read data. A store to a protected register lands only when the bus write immediately before it was a single-byte write to a write-only unlock register. Every other store to a protected register is thrown away and raises a sticky error flag.

Software unlocks by writing any byte to the unlock register and then writes the target register. Reads may fall between the two writes without breaking the sequence. Any write at all closes the window again. The protected values drive the outputs `pll_mul_o` and `flash_mode_o`, and the error flag drives `seq_err_o`. The multiplier circuit and the flash controller behind them are outside this block.

Top module: `prot_reg_guard`

## Requirements
- R1: A read of the unlock register (word 0xFFFFF800) returns 0 and does not change the armed state.
- R2: The guard arms only on a write to 0xFFFFF800 with byte enables exactly 4'b0001. A write there with any other byte-enable pattern does not arm the guard.
- R3: Every data byte written to the unlock register arms the guard. The value is not compared.
- R4: The clock control register (0xFFFFF804) holds the multiplier field in bits [1:0]: 00 = 10x, 01 = 5x, 10 = 2.5x, 11 = 1x. A write with be[0] set updates the field only when the guard is armed. The field is driven on `pll_mul_o` and read back in bits [1:0].
- R5: The flash mode register (0xFFFFF808) is 8 bits wide on byte lane 0. A write with be[0] set updates it only when the guard is armed. Its value is driven on `flash_mode_o` and read back in bits [7:0].
- R6: A write with be[0] set to a protected register while the guard is disarmed leaves both protected registers unchanged and sets the error flag from the next cycle on.
- R7: The guard disarms after the first bus write that follows the unlock write, whatever the address. Only that one write may update a protected register. A write to the unlock register re-arms the guard.
- R8: The error flag is bit 0 of the status register (0xFFFFF80C) and is driven on `seq_err_o`. It stays set until a write with be[0] set and wdata[0] = 0 clears it. Writing 1 has no effect.
- R9: After reset the guard is disarmed, the error flag is 0, `pll_mul_o` is 2'b11 (1x) and `flash_mode_o` is 0.
- R10: Read accesses (re_i without we_i) never consume the armed state.
- R11: `rdata_o` is combinational. It is valid in the cycle that re_i is high and is 0 when re_i is low or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables, bit n selects lane n |
| we_i | input | 1 | Write strobe, one write per cycle |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data |
| pll_mul_o | output | 2 | Clock multiplier select |
| flash_mode_o | output | 8 | Flash programming mode byte |
| seq_err_o | output | 1 | Sticky sequence-error flag |

## Verification
The unlock sequence is tried in three forms. The first is a clean unlock followed by a protected store, each time with a different unlock byte, which shows the data is not checked. The second is an unlock followed by reads before the store, which separates write-only consumption from consumption by any access. The third is an unlock followed by an unrelated write and only then the store, which shows the window lasts exactly one write. Bare stores, partial-lane unlock writes and back-to-back unlocks show that discarding and error flagging are kept apart from re-arming. Writes of 1 and then 0 to the status bit show that the flag is sticky.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned WORD_LSB = $clog2(BE_W);

  localparam logic [ADDR_W-1:0] UNLOCK_ADDR = 32'hFFFF_F800;
  localparam logic [ADDR_W-1:0] CLKSEL_ADDR = 32'hFFFF_F804;
  localparam logic [ADDR_W-1:0] FLASH_ADDR  = 32'hFFFF_F808;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 32'hFFFF_F80C;

  localparam int unsigned MUL_W   = 2;
  localparam int unsigned FMODE_W = 8;
  localparam logic [MUL_W-1:0] MUL_RST = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_UNLOCK,
    SEL_CLKSEL,
    SEL_FLASH,
    SEL_STATUS
  } reg_sel_e;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import prot_guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              unlock_wr_o,
  output logic              clksel_wr_o,
  output logic              flash_wr_o,
  output logic              status_wr_o
);
  localparam logic [BE_W-1:0] LANE0_ONLY = BE_W'(1);

  logic [ADDR_W-1:WORD_LSB] word;
  assign word = addr_i[ADDR_W-1:WORD_LSB];

  always_comb begin
    sel_o = SEL_NONE;
    if (word == UNLOCK_ADDR[ADDR_W-1:WORD_LSB])      sel_o = SEL_UNLOCK;
    else if (word == CLKSEL_ADDR[ADDR_W-1:WORD_LSB]) sel_o = SEL_CLKSEL;
    else if (word == FLASH_ADDR[ADDR_W-1:WORD_LSB])  sel_o = SEL_FLASH;
    else if (word == STATUS_ADDR[ADDR_W-1:WORD_LSB]) sel_o = SEL_STATUS;
  end

  // unlock needs an exact single-byte access on lane 0
  assign unlock_wr_o = we_i && (sel_o == SEL_UNLOCK) && (be_i == LANE0_ONLY);
  assign clksel_wr_o = we_i && (sel_o == SEL_CLKSEL) && be_i[0];
  assign flash_wr_o  = we_i && (sel_o == SEL_FLASH)  && be_i[0];
  assign status_wr_o = we_i && (sel_o == SEL_STATUS) && be_i[0];
endmodule

// File: rtl/guard_arm.sv
module guard_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic unlock_wr_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_o <= 1'b0;
    else if (unlock_wr_i) armed_o <= 1'b1;
    else if (we_i)        armed_o <= 1'b0;
  end

  AST_UNLOCK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_wr_i |=> armed_o); // R3
  AST_WRITE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlock_wr_i) |=> !armed_o); // R7
  AST_READ_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(armed_o)); // R10
endmodule

// File: rtl/guard_prot_regs.sv
module guard_prot_regs
  import prot_guard_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               armed_i,
  input  logic               clksel_wr_i,
  input  logic               flash_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [MUL_W-1:0]   mul_o,
  output logic [FMODE_W-1:0] fmode_o,
  output logic               bad_store_o
);
  logic [1:0] wr_req, wr_ok;
  assign wr_req = {flash_wr_i, clksel_wr_i};
  assign wr_ok  = wr_req & {2{armed_i}};
  assign bad_store_o = |wr_req && !armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mul_o <= MUL_RST;
    else if (wr_ok[0]) mul_o <= wdata_i[MUL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fmode_o <= '0;
    else if (wr_ok[1]) fmode_o <= wdata_i[FMODE_W-1:0];
  end

  AST_LOCKED_MUL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(mul_o)); // R4
  AST_LOCKED_FMODE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(fmode_o)); // R5
  AST_ARMED_MUL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && clksel_wr_i) |=> (mul_o == $past(wdata_i[MUL_W-1:0]))); // R4
endmodule

// File: rtl/guard_status.sv
module guard_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_store_i,
  input  logic status_wr_i,
  input  logic wbit_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      err_o <= 1'b0;
    else if (bad_store_i)             err_o <= 1'b1;
    else if (status_wr_i && !wbit_i)  err_o <= 1'b0;
  end

  AST_BAD_STORE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_store_i |=> err_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(status_wr_i && !wbit_i)) |=> err_o); // R8
endmodule

// File: rtl/prot_reg_guard.sv
module prot_reg_guard
  import prot_guard_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [MUL_W-1:0]   pll_mul_o,
  output logic [FMODE_W-1:0] flash_mode_o,
  output logic               seq_err_o
);
  reg_sel_e sel;
  logic unlock_wr, clksel_wr, flash_wr, status_wr;
  logic armed, bad_store;

  guard_decode i_decode (
    .addr_i      (addr_i),
    .be_i        (be_i),
    .we_i        (we_i),
    .sel_o       (sel),
    .unlock_wr_o (unlock_wr),
    .clksel_wr_o (clksel_wr),
    .flash_wr_o  (flash_wr),
    .status_wr_o (status_wr)
  );

  guard_arm i_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .unlock_wr_i (unlock_wr),
    .armed_o     (armed)
  );

  guard_prot_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .armed_i     (armed),
    .clksel_wr_i (clksel_wr),
    .flash_wr_i  (flash_wr),
    .wdata_i     (wdata_i),
    .mul_o       (pll_mul_o),
    .fmode_o     (flash_mode_o),
    .bad_store_o (bad_store)
  );

  guard_status i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bad_store_i (bad_store),
    .status_wr_i (status_wr),
    .wbit_i      (wdata_i[0]),
    .err_o       (seq_err_o)
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      case (sel)
        SEL_CLKSEL: rdata_o = DATA_W'(pll_mul_o);
        SEL_FLASH:  rdata_o = DATA_W'(flash_mode_o);
        SEL_STATUS: rdata_o = DATA_W'(seq_err_o);
        default:    rdata_o = '0; // unlock register is write-only
      endcase
    end
  end

  always_comb begin
    if (re_i && sel == SEL_UNLOCK)
      AST_UNLOCK_READ_ZERO: assert (rdata_o == '0); // R1
  end
endmodule

// File: tb/test_prot_reg_guard.sv
module test_prot_reg_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  mul;
  logic [7:0]  fmode;
  logic        err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit        m_armed;
  bit [1:0]  m_mul;
  bit [7:0]  m_fm;
  bit        m_err;

  localparam bit [31:0] A_UNL = 32'hFFFF_F800;
  localparam bit [31:0] A_CLK = 32'hFFFF_F804;
  localparam bit [31:0] A_FLS = 32'hFFFF_F808;
  localparam bit [31:0] A_STA = 32'hFFFF_F80C;
  localparam bit [31:0] A_OTH = 32'hFFFF_F900;

  always #5 clk = ~clk;

  prot_reg_guard i_prot_reg_guard (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pll_mul_o(mul),
    .flash_mode_o(fmode), .seq_err_o(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(bit [31:0] a);
    case (a[31:2])
      A_CLK[31:2]: return {30'd0, m_mul};
      A_FLS[31:2]: return {24'd0, m_fm};
      A_STA[31:2]: return {31'd0, m_err};
      default:     return 32'd0;
    endcase
  endfunction

  // one bus cycle: drive, check at negedge, clock, update model
  task automatic cyc(bit w, bit r, bit [31:0] a, bit [31:0] d, bit [3:0] b, string tag);
    bit ok_unl;
    we = w; re = r; addr = a; wdata = d; be = b;
    @(negedge clk);
    chk({tag, " rdata"}, rdata, r ? m_read(a) : 32'd0);
    chk({tag, " mul"}, {30'd0, mul}, {30'd0, m_mul});
    chk({tag, " fmode"}, {24'd0, fmode}, {24'd0, m_fm});
    chk({tag, " err"}, {31'd0, err}, {31'd0, m_err});
    @(posedge clk);
    if (w) begin
      ok_unl = (a[31:2] == A_UNL[31:2]) && (b == 4'b0001);
      if (a[31:2] == A_CLK[31:2] && b[0]) begin
        if (m_armed) m_mul = d[1:0]; else m_err = 1;
      end
      if (a[31:2] == A_FLS[31:2] && b[0]) begin
        if (m_armed) m_fm = d[7:0]; else m_err = 1;
      end
      if (a[31:2] == A_STA[31:2] && b[0] && !d[0]) m_err = 0;
      m_armed = ok_unl;
    end
    #1;
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 32'd0, 32'd0, 4'd0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_armed = 0; m_mul = 2'b11; m_fm = 8'h00; m_err = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset values
    chk("R9 mul reset", {30'd0, mul}, 32'd3);
    chk("R9 fmode reset", {24'd0, fmode}, 32'd0);
    chk("R9 err reset", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: unlock register reads as zero
    cyc(0, 1, A_UNL, 0, 4'hF, "R1 read unlock");
    // R6: bare store is dropped and flagged
    cyc(1, 0, A_CLK, 32'h0, 4'b0001, "R6 bare clk store");
    cyc(0, 1, A_CLK, 0, 4'hF, "R6 clk unchanged");
    cyc(0, 1, A_STA, 0, 4'hF, "R8 status read");
    // R8: writing 1 keeps, writing 0 clears
    cyc(1, 0, A_STA, 32'h1, 4'b0001, "R8 write one");
    cyc(1, 0, A_STA, 32'h0, 4'b0001, "R8 write zero");
    idle("R8 cleared");
    // R3/R4: unlock then each encoding with different unlock bytes
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, A_UNL, 32'h5A + 32'(k * 37), 4'b0001, "R3 unlock byte");
      cyc(1, 0, A_CLK, 32'(k), 4'b0001, "R4 armed clk write");
      cyc(0, 1, A_CLK, 0, 4'hF, "R4 clk readback");
    end
    // R5: flash mode
    cyc(1, 0, A_UNL, 32'h00, 4'b0001, "R3 unlock zero");
    cyc(1, 0, A_FLS, 32'hC3, 4'b0001, "R5 armed flash write");
    cyc(0, 1, A_FLS, 0, 4'hF, "R5 flash readback");
    // R10: reads between unlock and store
    cyc(1, 0, A_UNL, 32'hFF, 4'b0001, "R10 unlock");
    cyc(0, 1, A_STA, 0, 4'hF, "R10 read 1");
    cyc(0, 1, A_UNL, 0, 4'hF, "R10 read 2");
    cyc(1, 0, A_FLS, 32'h3C, 4'b0001, "R10 store after reads");
    idle("R10 applied");
    // R7: unrelated write consumes the window
    cyc(1, 0, A_UNL, 32'h11, 4'b0001, "R7 unlock");
    cyc(1, 0, A_OTH, 32'h22, 4'hF, "R7 other write");
    cyc(1, 0, A_FLS, 32'h99, 4'b0001, "R7 late store");
    idle("R7 dropped");
    cyc(1, 0, A_STA, 32'h0, 4'b0001, "R8 clear");
    // R7: only one store per unlock; re-unlock re-arms
    cyc(1, 0, A_UNL, 32'h01, 4'b0001, "R7 unlock");
    cyc(1, 0, A_UNL, 32'h02, 4'b0001, "R7 re-unlock");
    cyc(1, 0, A_CLK, 32'h2, 4'b0001, "R7 store after re-unlock");
    cyc(1, 0, A_CLK, 32'h1, 4'b0001, "R7 second store dropped");
    idle("R7 check");
    cyc(1, 0, A_STA, 32'h0, 4'b0001, "R8 clear");
    // R2: partial or wide unlock writes do not arm
    cyc(1, 0, A_UNL, 32'h77, 4'b0011, "R2 wide unlock");
    cyc(1, 0, A_FLS, 32'h44, 4'b0001, "R2 store after wide");
    cyc(1, 0, A_STA, 32'h0, 4'b0001, "R8 clear");
    cyc(1, 0, A_UNL, 32'h7700, 4'b0010, "R2 lane1 unlock");
    cyc(1, 0, A_CLK, 32'h3, 4'b0001, "R2 store after lane1");
    // R11: read strobe low gives zero, unmapped gives zero
    cyc(0, 0, A_FLS, 0, 4'hF, "R11 no strobe");
    cyc(0, 1, A_OTH, 0, 4'hF, "R11 unmapped");
    // R1: unlock read does not arm
    cyc(1, 0, A_STA, 32'h0, 4'b0001, "R8 clear");
    cyc(0, 1, A_UNL, 0, 4'hF, "R1 read");
    cyc(1, 0, A_CLK, 32'h0, 4'b0001, "R1 store after read");
    idle("R1 final");
    chk("R4 final mul", {30'd0, mul}, {30'd0, m_mul});
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule